// File: doc/BRIEF.md
# Vblank-Synchronized Fractional Clock-Enable Divider

This block sits in the fast clock domain and produces a single-cycle clock-enable strobe. The strobe's average rate is the fast clock divided by a selectable ratio and then by a fixed factor of two. The selectable ratios are 1, 1.5, 2 and 4. No derived or gated clock is created. Downstream logic samples on the fast clock and qualifies its registers with the strobe.

Software places a new ratio code in a shadow register at any time. The running ratio changes only when a vertical-blank-start pulse from the one display pipe that stays active is sampled. The pipe therefore never sees a ratio change in the middle of a frame. A status output shows the code that is currently running. Software polls it until it matches the code it requested.

The ratio is kept internally in half-step units: 2, 3, 4 or 8. Each fast cycle, an accumulator advances by two and removes the half-step divisor whenever it can. This gives a first-stage enable at twice the final rate. A toggle stage then passes every second first-stage enable. For the 1.5 ratio, the first stage fires on two of every three cycles, and the final strobe lands on every third cycle.

Top module: `frac_clk_div`

## Requirements
- R1: While the synchronous active-high `rst` is high, and in the first cycle after it falls, `div_status` reads 0 and no update is pending. The divider restarts at ratio 1, giving exactly 120 strobes in the 240 cycles that follow reset.
- R2: Codes map to half-step divisors as follows: 0 gives 2, 1 gives 3, 2 gives 4 and 3 gives 8. With divisor d running, `clk_en` pulses exactly 240/d times in the 240 cycles that follow a ratio change.
- R3: `clk_en` is never high in two consecutive cycles. The 1.5 ratio produces evenly spaced strobes, one every three cycles.
- R4: A valid write (`cfg_wr` high with bits [2:1]... more precisely, bit 2 of `cfg_code` low) only loads the shadow. `div_status` is unchanged in every cycle that does not sample `vblank_start` high.
- R5: In a cycle where `vblank_start` is high and an update is pending, the shadow code becomes active, and `div_status` shows it from the next cycle. The strobe pattern restarts from its initial phase at the same edge.
- R6: A write with bit 2 of `cfg_code` set (codes 4 to 7) is invalid. It changes neither the shadow nor the pending state, so a later vblank pulse leaves the ratio as it was.
- R7: When several valid writes arrive before one vblank pulse, only the last of them takes effect.
- R8: When a valid write and `vblank_start` occur in the same cycle, the code written in that cycle is the one that becomes active.
- R9: A vblank pulse with no pending update leaves `div_status` and the strobe pattern unchanged.
- R10: `div_status` always holds one of the four defined codes, so bit 2 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Write strobe for the requested ratio code |
| cfg_code | input | 3 | Requested ratio code: 0 to 3 are valid, 4 to 7 are invalid |
| vblank_start | input | 1 | Start-of-vertical-blank pulse of the pipe that stays active |
| clk_en | output | 1 | Clock-enable strobe at clock / ratio / 2 |
| div_status | output | 3 | Code of the ratio currently running |

## Verification
Two functions can fall in the same cycle. A software write can arrive in exactly the cycle in which the vblank pulse commits the shadow. An invalid write can also meet a vblank pulse while nothing valid is pending.

Both collisions are provoked by directed steps, and also by random stimulus in which writes, invalid codes and vblank pulses are drawn independently each cycle. A bench-side model of the shadow, pending flag and active code judges the status every cycle. Strobe counts over fixed 240-cycle windows after each commit judge the ratio that actually took effect.

// File: rtl/frac_clk_div.sv
module frac_clk_div #(
  parameter int CODE_W = 3,
  parameter int ACC_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [CODE_W-1:0] cfg_code,
  input  logic              vblank_start,
  output logic              clk_en,
  output logic [CODE_W-1:0] div_status
);
  localparam int SUM_W = ACC_W + 1;

  logic [CODE_W-1:0] shadow_q, active_q, shadow_d;
  logic              pend_q, pend_d, wr_ok, commit;
  logic [ACC_W-1:0]  acc_q;
  logic              tog_q, stage_en;
  logic [SUM_W-1:0]  acc_sum, half_div;

  function automatic logic [SUM_W-1:0] half_steps(input logic [1:0] c);
    case (c)
      2'd0:    half_steps = SUM_W'(2);
      2'd1:    half_steps = SUM_W'(3);
      2'd2:    half_steps = SUM_W'(4);
      default: half_steps = SUM_W'(8);
    endcase
  endfunction

  assign wr_ok    = cfg_wr && (cfg_code[CODE_W-1:2] == '0);
  assign shadow_d = wr_ok ? cfg_code : shadow_q;
  assign pend_d   = wr_ok || pend_q;
  assign commit   = vblank_start && pend_d;

  assign half_div = half_steps(active_q[1:0]);
  assign acc_sum  = SUM_W'(acc_q) + SUM_W'(2);
  assign stage_en = acc_sum >= half_div;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      active_q <= '0;
      pend_q   <= 1'b0;
      acc_q    <= '0;
      tog_q    <= 1'b0;
    end else begin
      shadow_q <= shadow_d;
      if (commit) begin
        active_q <= shadow_d;
        pend_q   <= 1'b0;
        acc_q    <= '0;
        tog_q    <= 1'b0;
      end else begin
        pend_q <= pend_d;
        acc_q  <= stage_en ? ACC_W'(acc_sum - half_div) : ACC_W'(acc_sum);
        tog_q  <= tog_q ^ stage_en;
      end
    end
  end

  assign clk_en     = stage_en && tog_q;
  assign div_status = active_q;

  // R3
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
    clk_en |=> !clk_en);

  // R4
  hold_without_vblank_chk: assert property (@(posedge clk) disable iff (rst)
    !vblank_start |=> $stable(div_status));

  // R8
  same_cycle_write_chk: assert property (@(posedge clk) disable iff (rst)
    (vblank_start && cfg_wr && cfg_code[CODE_W-1:2] == '0) |=> div_status == $past(cfg_code));

  // R6
  invalid_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (vblank_start && !pend_q && cfg_wr && cfg_code[CODE_W-1:2] != '0) |=> $stable(div_status));

  // R10
  status_legal_chk: assert property (@(posedge clk) disable iff (rst)
    div_status[CODE_W-1:2] == '0);
endmodule

// File: tb/frac_clk_div_tb_top.sv
module frac_clk_div_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [2:0] cfg_code = 3'd0;
  logic       vblank_start = 1'b0;
  logic       clk_en;
  logic [2:0] div_status;

  int checks = 0;
  int failures = 0;
  logic [2:0] m_shadow = 3'd0, m_active = 3'd0;
  logic       m_pend = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  frac_clk_div dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_code(cfg_code),
    .vblank_start(vblank_start), .clk_en(clk_en), .div_status(div_status)
  );

  function automatic int half_div(input logic [2:0] c);
    case (c[1:0])
      2'd0: return 2;
      2'd1: return 3;
      2'd2: return 4;
      default: return 8;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [2:0] c, input logic v, input string req);
    logic ok;
    logic [2:0] nsh;
    cfg_wr = w; cfg_code = c; vblank_start = v;
    ok  = w && !c[2];
    nsh = ok ? c : m_shadow;
    if (v && (ok || m_pend)) begin
      m_active = nsh; m_pend = 1'b0;
    end else m_pend = ok || m_pend;
    m_shadow = nsh;
    @(negedge clk);
    check(req, div_status, m_active);
  endtask

  task automatic count_window(input string req, input int exp);
    int n = 0;
    int prev = 0;
    int b2b = 0;
    cfg_wr = 1'b0; vblank_start = 1'b0;
    for (int i = 0; i < 240; i++) begin
      if (clk_en && prev) b2b++;
      prev = clk_en;
      n += clk_en;
      @(negedge clk);
    end
    check(req, n, exp);
    check("R3 back-to-back strobes", b2b, 0);
  endtask

  initial begin
    #(5ns * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c1c1));
    repeat (4) @(negedge clk);
    check("R1 status in reset", div_status, 0);
    rst = 1'b0;
    check("R1 status after reset", div_status, 0);
    count_window("R1 ratio 1 after reset", 120);

    for (int c = 0; c < 4; c++) begin
      step(1'b1, 3'(c), 1'b0, "R4 write held in shadow");
      step(1'b0, 3'd0, 1'b0, "R4 status unchanged");
      step(1'b0, 3'd0, 1'b1, "R5 commit at vblank");
      count_window("R2 strobe count", 240 / half_div(3'(c)));
    end

    step(1'b1, 3'd1, 1'b1, "R5 commit to 1.5");
    count_window("R3 ratio 1.5 spacing", 80);

    step(1'b1, 3'd6, 1'b0, "R6 invalid write");
    step(1'b0, 3'd0, 1'b1, "R6 vblank after invalid");
    check("R6 ratio kept", div_status, 1);
    count_window("R9 pattern intact", 80);

    step(1'b1, 3'd3, 1'b0, "R7 first write");
    step(1'b1, 3'd0, 1'b0, "R7 second write");
    step(1'b1, 3'd2, 1'b0, "R7 last write");
    step(1'b0, 3'd0, 1'b1, "R7 commit");
    check("R7 last write wins", div_status, 2);
    count_window("R7 ratio 2 count", 60);

    step(1'b1, 3'd3, 1'b0, "R8 earlier write");
    step(1'b1, 3'd0, 1'b1, "R8 write with vblank");
    check("R8 same-cycle code", div_status, 0);

    step(1'b1, 3'd5, 1'b1, "R6 invalid with vblank");
    check("R6 invalid with vblank", div_status, 0);
    step(1'b0, 3'd0, 1'b1, "R9 empty vblank");
    check("R9 no change", div_status, 0);

    for (int i = 0; i < 3000; i++) begin
      logic w, v;
      logic [2:0] c;
      w = ($urandom % 4) == 0;
      c = 3'($urandom % 8);
      v = ($urandom % 6) == 0;
      step(w, c, v, "R5 R8 random status");
      check("R10 legal status", int'(div_status[2]), 0);
    end

    step(1'b1, 3'd3, 1'b1, "R2 final commit");
    count_window("R2 ratio 4 count", 30);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule